// File: doc/BRIEF.md
# Ramped Two-Frequency Tone Source

This block turns out a digital sampled sine tone for a later converter stage. A single select bit picks one of two tone frequencies, nominally 12 kHz and 16 kHz. A phase accumulator runs once per sample clock, and the top bits of its phase address a 64-point sine lookup. The looked-up value is then scaled by a gain taken from the current envelope level.

The envelope never switches the tone abruptly. While the enable input is high, a level counter climbs one step on each envelope tick until it reaches the top of 16 levels. While enable is low, it falls one step per tick until it reaches zero. Adjacent levels differ by 2 dB, and level zero gives an output of exactly zero, which is the bias. The tick period comes from the sample rate and the total ramp time, which is about 4.5 ms per full rise or fall.

The output is a signed sample word, together with a busy flag that stays high while the envelope is above zero. The clock is the sample clock. Reset is synchronous and active high.

Top module: `tone_ramp_gen`

## Requirements
- R1: Each cycle the 16-bit phase advances by INC_LO = 8192 when freq_sel = 0, or by INC_HI = 10923 when freq_sel = 1. Here INC = round(f·2^16/SAMPLE_HZ), with SAMPLE_HZ = 96000, f = 12000 for INC_LO and f = 16000 for INC_HI. sample_q equals floor(W·G/65536), computed from the phase and level held two clock edges earlier. W = round(32767·sin((j+0.5)·2π/64)), where j is phase bits [15:10].
- R2: The gain at level k (1..15) is round(65535·10^(-(15-k)/10)), so adjacent levels differ by 2 dB. Level 15 is full scale, which gives a peak |sample_q| of 32727.
- R3: An envelope tick fires once every STEP_CYCLES = 27 cycles, counted from the end of reset. On a tick with tone_en = 1, the level rises by one and saturates at 15. The level changes on no other cycle.
- R4: On a tick with tone_en = 0, the level falls by one and stops at 0. While the level is 0, sample_q is exactly 0.
- R5: A change of tone_en during a ramp reverses the direction from the current level, one step per tick, with no jump.
- R6: A change of freq_sel alters the increment from the next cycle on, and does not reset the phase.
- R7: busy is high exactly when the envelope level is non-zero, and it follows the level in the same cycle the level register changes.
- R8: While rst is high, on the next edge the phase, level, tick counter and pipeline are cleared, so that sample_q = 0 and busy = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | 1 ramps the envelope up, 0 ramps it down |
| freq_sel | input | 1 | 0 selects 12 kHz, 1 selects 16 kHz |
| sample_q | output | 16 | Signed tone sample, 0 at bias |
| busy | output | 1 | High while the envelope level is non-zero |

## Verification
The phase and the level registers update on the edge at which the inputs are sampled, and busy follows the level on that same edge. The sine lookup and the gain lookup add one register each, and the multiply stage adds another, so sample_q reflects the phase and level from two edges earlier. The bench's reference model updates on the same posedge, keeps a two-deep history of phase and level, and compares sample_q against the older entry at the following negedge. The bench allows a tolerance of a few LSB for table rounding. Ramp-end and reversal checks wait a whole number of 27-cycle ticks plus margin before sampling busy.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int LVL_W     = 4;
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int LUT_W     = 6;
  localparam int QTR_W     = LUT_W - 2;
  localparam int AMP_W     = 16;
  localparam int GAIN_W    = 16;

  typedef logic [LVL_W-1:0] level_t;

  // First quarter of a 64-point sine, sampled at half-index offsets.
  function automatic logic [AMP_W-2:0] quarter_sine(input logic [QTR_W-1:0] i);
    case (i)
      4'd0:  return 15'd1608;
      4'd1:  return 15'd4808;
      4'd2:  return 15'd7962;
      4'd3:  return 15'd11039;
      4'd4:  return 15'd14010;
      4'd5:  return 15'd16846;
      4'd6:  return 15'd19519;
      4'd7:  return 15'd22005;
      4'd8:  return 15'd24279;
      4'd9:  return 15'd26319;
      4'd10: return 15'd28105;
      4'd11: return 15'd29621;
      4'd12: return 15'd30852;
      4'd13: return 15'd31785;
      4'd14: return 15'd32412;
      default: return 15'd32728;
    endcase
  endfunction

  // Envelope gain per level: 2 dB apart, level 0 is silence.
  function automatic logic [GAIN_W-1:0] level_gain(input level_t k);
    case (k)
      4'd0:  return 16'd0;
      4'd1:  return 16'd2609;
      4'd2:  return 16'd3285;
      4'd3:  return 16'd4135;
      4'd4:  return 16'd5206;
      4'd5:  return 16'd6554;
      4'd6:  return 16'd8250;
      4'd7:  return 16'd10387;
      4'd8:  return 16'd13076;
      4'd9:  return 16'd16462;
      4'd10: return 16'd20724;
      4'd11: return 16'd26090;
      4'd12: return 16'd32845;
      4'd13: return 16'd41350;
      4'd14: return 16'd52057;
      default: return 16'd65535;
    endcase
  endfunction
endpackage

// File: rtl/tone_phase_accum.sv
module tone_phase_accum #(
  parameter int PHASE_W = 16,
  parameter logic [PHASE_W-1:0] INC_LO = 8192,
  parameter logic [PHASE_W-1:0] INC_HI = 10923
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               freq_sel,
  output logic [PHASE_W-1:0] phase_q
);
  logic [PHASE_W-1:0] inc;

  assign inc = freq_sel ? INC_HI : INC_LO;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + inc;
  end

  // R1: phase moves every running cycle, never stalls
  a_r1_phase_moves: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !$stable(phase_q));
endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom
  import tone_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LUT_W-1:0]        idx,
  output logic signed [AMP_W-1:0] wave_q
);
  logic [1:0]       quad;
  logic [QTR_W-1:0] off;
  logic [QTR_W-1:0] addr;
  logic [AMP_W-2:0] mag;

  assign quad = idx[LUT_W-1 -: 2];
  assign off  = idx[QTR_W-1:0];
  assign addr = quad[0] ? ~off : off;
  assign mag  = quarter_sine(addr);

  always_ff @(posedge clk) begin
    if (rst)          wave_q <= '0;
    else if (quad[1]) wave_q <= -$signed({1'b0, mag});
    else              wave_q <= $signed({1'b0, mag});
  end
endmodule

// File: rtl/tone_env_seq.sv
module tone_env_seq
  import tone_pkg::*;
#(
  parameter int STEP_CYCLES = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tone_en,
  output level_t            level_q,
  output logic [GAIN_W-1:0] gain_q
);
  localparam int TICK_W = $clog2(STEP_CYCLES + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_CYCLES - 1);
  localparam level_t LVL_MAX = level_t'(NUM_LVL - 1);

  logic [TICK_W-1:0] tick_cnt;
  logic              tick;

  assign tick = (tick_cnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst)       tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else if (tick) begin
      if (tone_en && level_q != LVL_MAX)  level_q <= level_q + 1'b1;
      else if (!tone_en && level_q != '0) level_q <= level_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= '0;
    else     gain_q <= level_gain(level_q);
  end

  // R3: level only moves on a tick
  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level_q));
  // R3: enabled tick climbs one level
  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (tick && tone_en && level_q != LVL_MAX) |=> (level_q == $past(level_q) + 1'b1));
  // R4: disabled tick falls one level
  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !tone_en && level_q != '0) |=> (level_q == $past(level_q) - 1'b1));
endmodule

// File: rtl/tone_ramp_gen.sv
module tone_ramp_gen
  import tone_pkg::*;
#(
  parameter int SAMPLE_HZ = 96000,
  parameter int FREQ_LO   = 12000,
  parameter int FREQ_HI   = 16000,
  parameter int RAMP_US   = 4500,
  parameter int PHASE_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tone_en,
  input  logic                    freq_sel,
  output logic signed [AMP_W-1:0] sample_q,
  output logic                    busy
);
  localparam longint PH_SPAN = longint'(1) << PHASE_W;
  localparam logic [PHASE_W-1:0] INC_LO =
    PHASE_W'((longint'(FREQ_LO) * PH_SPAN + SAMPLE_HZ / 2) / SAMPLE_HZ);
  localparam logic [PHASE_W-1:0] INC_HI =
    PHASE_W'((longint'(FREQ_HI) * PH_SPAN + SAMPLE_HZ / 2) / SAMPLE_HZ);
  localparam int STEP_CYCLES =
    int'((longint'(SAMPLE_HZ) * RAMP_US) / (longint'(NUM_LVL) * 1000000));
  localparam int PROD_W = AMP_W + GAIN_W + 1;

  logic [PHASE_W-1:0]      phase;
  logic signed [AMP_W-1:0] wave_q;
  level_t                  level;
  logic [GAIN_W-1:0]       gain_q;
  logic signed [PROD_W-1:0] prod;

  tone_phase_accum #(.PHASE_W(PHASE_W), .INC_LO(INC_LO), .INC_HI(INC_HI)) u_phase (
    .clk(clk), .rst(rst), .freq_sel(freq_sel), .phase_q(phase));

  tone_sine_rom u_rom (
    .clk(clk), .rst(rst), .idx(phase[PHASE_W-1 -: LUT_W]), .wave_q(wave_q));

  tone_env_seq #(.STEP_CYCLES(STEP_CYCLES)) u_env (
    .clk(clk), .rst(rst), .tone_en(tone_en), .level_q(level), .gain_q(gain_q));

  assign prod = wave_q * $signed({1'b0, gain_q});

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else     sample_q <= prod[GAIN_W +: AMP_W];
  end

  assign busy = (level != '0);

  // R4: level zero yields exact bias two edges later
  a_r4_bias_out: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> ##1 (sample_q == '0));
  // R8: in reset the output drops to bias on the next edge
  a_r8_reset_bias: assert property (@(posedge clk)
    rst |=> (sample_q == '0 && !busy));
endmodule

// File: tb/tone_ramp_gen_bench.sv
module tone_ramp_gen_bench;
  localparam int STEP   = 27;
  localparam int INC_LO = 8192;
  localparam int INC_HI = 10923;
  localparam int TOL    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_en = 1'b0;
  logic freq_sel = 1'b0;
  logic signed [15:0] sample_q;
  logic busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R8";

  int m_ph, m_lv, m_cnt, h1_ph, h1_lv, h2_ph, h2_lv;

  always #10 clk = ~clk;

  tone_ramp_gen u_tone_ramp_gen (
    .clk(clk), .rst(rst), .tone_en(tone_en), .freq_sel(freq_sel),
    .sample_q(sample_q), .busy(busy));

  function automatic longint exp_wave(int j);
    real a;
    a = 32767.0 * $sin((j + 0.5) * 2.0 * 3.14159265358979 / 64.0);
    return longint'(a);
  endfunction

  function automatic longint exp_gain(int k);
    if (k == 0) return 0;
    return longint'(65535.0 * $pow(10.0, -(15 - k) / 10.0));
  endfunction

  function automatic longint exp_sample(int ph, int k);
    return (exp_wave(ph >> 10) * exp_gain(k)) >>> 16;
  endfunction

  // Reference model from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_lv <= 0; m_cnt <= 0;
      h1_ph <= 0; h1_lv <= 0; h2_ph <= 0; h2_lv <= 0;
    end else begin
      m_ph <= (m_ph + (freq_sel ? INC_HI : INC_LO)) & 16'hFFFF;
      if (m_cnt == STEP - 1) begin
        m_cnt <= 0;
        if (tone_en && m_lv < 15) m_lv <= m_lv + 1;
        else if (!tone_en && m_lv > 0) m_lv <= m_lv - 1;
      end else m_cnt <= m_cnt + 1;
      h1_ph <= m_ph; h1_lv <= m_lv;
      h2_ph <= h1_ph; h2_lv <= h1_lv;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp, int tol);
    longint d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_tag, "sample", longint'(sample_q), exp_sample(h2_ph, h2_lv), TOL);
      check("R7", "busy", longint'(busy), longint'(m_lv != 0), 0);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int seed_init;
  int peak;

  initial begin
    seed_init = $urandom(32'd20240);
    wait_cyc(4);
    check("R8", "reset sample", longint'(sample_q), 0, 0);
    check("R8", "reset busy", longint'(busy), 0, 0);
    rst = 1'b0;

    cur_tag = "R3";
    tone_en = 1'b1;
    wait_cyc(16 * STEP + 8);
    check("R3", "busy after rise", longint'(busy), 1, 0);

    cur_tag = "R2";
    peak = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (sample_q > peak) peak = sample_q;
      if (-sample_q > peak) peak = -sample_q;
    end
    check("R2", "full-scale peak", peak, 32727, TOL);

    cur_tag = "R6";
    for (int i = 0; i < 30; i++) begin
      freq_sel = ~freq_sel;
      wait_cyc(7);
    end

    cur_tag = "R4";
    tone_en = 1'b0;
    wait_cyc(16 * STEP + 8);
    check("R4", "busy after fall", longint'(busy), 0, 0);
    check("R4", "bias after fall", longint'(sample_q), 0, 0);

    cur_tag = "R5";
    tone_en = 1'b1;
    wait_cyc(5 * STEP);
    check("R5", "busy mid-rise", longint'(busy), 1, 0);
    tone_en = 1'b0;
    wait_cyc(7 * STEP);
    check("R5", "busy after reversal", longint'(busy), 0, 0);

    cur_tag = "R8";
    tone_en = 1'b1;
    wait_cyc(300);
    rst = 1'b1;
    wait_cyc(1);
    check("R8", "mid-ramp reset sample", longint'(sample_q), 0, 0);
    check("R8", "mid-ramp reset busy", longint'(busy), 0, 0);
    wait_cyc(1);
    rst = 1'b0;

    cur_tag = "R1";
    for (int s = 0; s < 30; s++) begin
      tone_en  = 1'($urandom % 2);
      freq_sel = 1'($urandom % 2);
      wait_cyc(50 + int'($urandom % 500));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule